// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Assembler

This block sits at the front of a small processor pipeline. It reads a program one byte at a time from a byte-wide memory with a fixed one-cycle read latency, works out from the first byte how many bytes the instruction spans (one, two or three), collects the remaining bytes from consecutive addresses, and presents the whole instruction as one record. The record carries the opcode, an 8-bit immediate and a 14-bit jump or call target.

A 14-bit program counter drives the read address and advances once per byte read. Finished records leave over a valid/ready handshake. While a record waits for the consumer, no further memory reads are issued. A redirect input reloads the program counter, which lets the execution stage steer fetching after a branch. Any instruction that is half collected, or a finished record still waiting, is thrown away.

Top module: `insn_gather`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `mem_addr` is 0x0000.
- R2: An opcode in neither the immediate class nor the address class is a one-byte instruction. Its record has `out_len` = 1, `out_imm` = 0x00 and `out_target` = 0x0000.
- R3: An opcode of the form 00 xxx 110 (bits 7:6 = 00, bits 2:0 = 110) is two bytes long. The record has `out_len` = 2, `out_imm` equal to the byte after the opcode, and `out_target` = 0x0000.
- R4: An opcode of the form 01 xxx 100 or 01 xxx 110 is three bytes long. The byte after the opcode is the low target byte and the byte after that is the high target byte. The record has `out_len` = 3, `out_imm` = 0x00 and `out_target` = {high[5:0], low[7:0]}. Bits 7:6 of the high byte have no effect.
- R5: Each byte is read from the address after the previous one, and the next instruction starts at the byte after the last byte of the current one. Read data is taken one cycle after `mem_rd` is high.
- R6: The program counter wraps from 0x3FFF to 0x0000, including in the middle of a multi-byte instruction.
- R7: Once `out_valid` is high, it stays high with all record fields unchanged until a cycle in which `out_ready` is high. During such a stall `mem_rd` is 0.
- R8: When `redir_valid` is high, `mem_rd` is 0 in that cycle. In the next cycle `mem_addr` equals `redir_pc` and `out_valid` is 0. A partly collected or waiting record is discarded, and the next record is the instruction at `redir_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_valid | input | 1 | Reload the program counter and flush |
| redir_pc | input | 14 | New fetch address |
| mem_rd | output | 1 | Read strobe for `mem_addr` |
| mem_addr | output | 14 | Byte read address (program counter) |
| mem_data | input | 8 | Read data, one cycle after `mem_rd` |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | First byte of the instruction |
| out_imm | output | 8 | Immediate byte (zero unless length 2) |
| out_target | output | 14 | Jump/call target (zero unless length 3) |
| out_len | output | 2 | Instruction length in bytes, 1 to 3 |

## Verification
The bench targets the following corner cases:
- A three-byte instruction whose high byte has its top two bits set. A design that kept those bits, or swapped the two address bytes, would report a wrong target.
- An opcode such as 00 000 100, which looks close to the immediate pattern. A classifier that is too loose would swallow the next opcode as an immediate.
- A three-byte instruction that straddles address 0x3FFF. A counter that did not wrap would read the high byte from the wrong place.
- Redirects issued in the middle of collecting bytes and while a record is stalled. A design that did not flush would emit a stale or mixed record.
- Stalls on the output. A design that kept fetching during a stall would skip or corrupt the next instruction.

// File: rtl/ig_pkg.sv
package ig_pkg;

    localparam int ADDR_W = 14;
    localparam int BYTE_W = 8;
    localparam int HI_W   = ADDR_W - BYTE_W;

    typedef logic [1:0] len_t;

    typedef struct packed {
        logic [BYTE_W-1:0] opcode;
        logic [BYTE_W-1:0] imm;
        logic [ADDR_W-1:0] target;
        len_t              len;
    } insn_rec_t;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_CAPT  = 2'd1,
        ST_HOLD  = 2'd2
    } asm_state_e;

    function automatic logic is_imm_op(input logic [BYTE_W-1:0] op);
        return (op[7:6] == 2'b00) && (op[2:0] == 3'b110);
    endfunction

endpackage

// File: rtl/ig_classify.sv
module ig_classify
    import ig_pkg::*;
#(
    parameter logic [7:0] LONG_SEL = 8'b0101_0000
) (
    input  logic [BYTE_W-1:0] op,
    output len_t              len
);
    logic long_op;

    assign long_op = (op[7:6] == 2'b01) && LONG_SEL[op[2:0]];

    always_comb begin
        if (is_imm_op(op))      len = 2'd2;
        else if (long_op)       len = 2'd3;
        else                    len = 2'd1;
    end

endmodule

// File: rtl/ig_pc.sv
module ig_pc #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] pc
);
    logic [W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst)       pc_q <= '0;
        else if (load) pc_q <= load_val;
        else if (step) pc_q <= pc_q + 1'b1;
    end

    assign pc = pc_q;

    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        ($past(step) && !$past(load) && ($past(pc_q) == {W{1'b1}})) |-> (pc_q == '0));

endmodule

// File: rtl/ig_assemble.sv
module ig_assemble
    import ig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [BYTE_W-1:0] mem_data,
    input  len_t              byte_len,
    input  logic              out_ready,
    output logic              rd_req,
    output logic              out_valid,
    output insn_rec_t         rec
);
    asm_state_e  st_q;
    logic [1:0]  idx_q;
    insn_rec_t   rec_q;
    logic        need_more;

    always_comb begin
        need_more = 1'b0;
        if (st_q == ST_CAPT) begin
            if (idx_q == 2'd0)      need_more = (byte_len != 2'd1);
            else if (idx_q == 2'd1) need_more = (rec_q.len == 2'd3);
        end
    end

    assign rd_req = !flush && ((st_q == ST_FETCH) || need_more ||
                               ((st_q == ST_HOLD) && out_ready));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_FETCH;
            idx_q <= 2'd0;
            rec_q <= '0;
        end else if (flush) begin
            st_q  <= ST_FETCH;
            idx_q <= 2'd0;
        end else begin
            case (st_q)
                ST_FETCH: begin
                    st_q  <= ST_CAPT;
                    idx_q <= 2'd0;
                end
                ST_CAPT: begin
                    case (idx_q)
                        2'd0: begin
                            rec_q.opcode <= mem_data;
                            rec_q.imm    <= '0;
                            rec_q.target <= '0;
                            rec_q.len    <= byte_len;
                            if (byte_len == 2'd1) st_q  <= ST_HOLD;
                            else                  idx_q <= 2'd1;
                        end
                        2'd1: begin
                            if (rec_q.len == 2'd2) begin
                                rec_q.imm <= mem_data;
                                st_q      <= ST_HOLD;
                            end else begin
                                rec_q.target[BYTE_W-1:0] <= mem_data;
                                idx_q                    <= 2'd2;
                            end
                        end
                        default: begin
                            rec_q.target[ADDR_W-1:BYTE_W] <= mem_data[HI_W-1:0];
                            st_q                          <= ST_HOLD;
                        end
                    endcase
                end
                ST_HOLD: begin
                    if (out_ready) begin
                        st_q  <= ST_CAPT;
                        idx_q <= 2'd0;
                    end
                end
                default: st_q <= ST_FETCH;
            endcase
        end
    end

    assign out_valid = (st_q == ST_HOLD);
    assign rec       = rec_q;

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(rec)));

    a_r7_no_read_stalled: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !rd_req);

    a_r3_len_class: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((rec.len == 2'd2) == is_imm_op(rec.opcode)));

    a_r2_short_clean: assert property (@(posedge clk) disable iff (rst)
        (out_valid && rec.len == 2'd1) |-> (rec.imm == '0 && rec.target == '0));

endmodule

// File: rtl/insn_gather.sv
module insn_gather
    import ig_pkg::*;
#(
    parameter logic [7:0] LONG_SEL = 8'b0101_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_pc,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_opcode,
    output logic [BYTE_W-1:0] out_imm,
    output logic [ADDR_W-1:0] out_target,
    output logic [1:0]        out_len
);
    len_t      byte_len;
    insn_rec_t rec;
    logic      rd_req;

    ig_classify #(.LONG_SEL(LONG_SEL)) u_class (
        .op  (mem_data),
        .len (byte_len)
    );

    ig_pc #(.W(ADDR_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .load     (redir_valid),
        .load_val (redir_pc),
        .step     (rd_req),
        .pc       (mem_addr)
    );

    ig_assemble u_asm (
        .clk       (clk),
        .rst       (rst),
        .flush     (redir_valid),
        .mem_data  (mem_data),
        .byte_len  (byte_len),
        .out_ready (out_ready),
        .rd_req    (rd_req),
        .out_valid (out_valid),
        .rec       (rec)
    );

    assign mem_rd     = rd_req;
    assign out_opcode = rec.opcode;
    assign out_imm    = rec.imm;
    assign out_target = rec.target;
    assign out_len    = rec.len;

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!out_valid && mem_addr == '0));

    a_r8_redirect_addr: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (mem_addr == $past(redir_pc) && !out_valid));

    a_r8_no_read: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> !mem_rd);

    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !redir_valid) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

// File: tb/sim_insn_gather.sv
`timescale 1ns/1ps
module sim_insn_gather;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        redir_valid = 1'b0;
    logic [13:0] redir_pc = '0;
    logic        mem_rd;
    logic [13:0] mem_addr;
    logic [7:0]  mem_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_opcode;
    logic [7:0]  out_imm;
    logic [13:0] out_target;
    logic [1:0]  out_len;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mem [64];

    always #4 clk = ~clk;

    always @(posedge clk) mem_data <= mem[mem_addr[5:0]];

    insn_gather u0 (
        .clk(clk), .rst(rst), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
        .out_imm(out_imm), .out_target(out_target), .out_len(out_len)
    );

    // {opcode, imm, target, len}
    localparam logic [31:0] VEC [10] = '{
        {8'hC1, 8'h00, 14'h0000, 2'd1},
        {8'h0E, 8'h5A, 14'h0000, 2'd2},
        {8'h44, 8'h00, 14'h1234, 2'd3},
        {8'h7E, 8'h00, 14'h3FFF, 2'd3},
        {8'h3E, 8'h00, 14'h0000, 2'd2},
        {8'h06, 8'hA5, 14'h0000, 2'd2},
        {8'h46, 8'h00, 14'h0000, 2'd3},
        {8'hFF, 8'h00, 14'h0000, 2'd1},
        {8'h04, 8'h00, 14'h0000, 2'd1},
        {8'h4C, 8'h00, 14'h3F01, 2'd3}
    };
    localparam string VREQ [10] = '{"R2", "R3", "R4", "R4", "R3",
                                    "R3", "R4", "R2", "R2", "R4"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cur_rec();
        return {out_opcode, out_imm, out_target, out_len};
    endfunction

    task automatic take(input string req, input logic [31:0] exp, input int stall);
        int waitc = 0;
        logic [31:0] snap;
        while (!out_valid && waitc < 50) begin
            @(negedge clk);
            waitc++;
        end
        check(req, {31'd0, out_valid}, 32'd1);
        snap = cur_rec();
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            check("R7", {30'd0, out_valid, mem_rd}, {30'd0, 1'b1, 1'b0});
            check("R7", cur_rec(), snap);
        end
        check(req, cur_rec(), exp);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic redirect(input logic [13:0] tgt);
        redir_valid = 1'b1;
        redir_pc    = tgt;
        #1;
        check("R8", {31'd0, mem_rd}, 32'd0);
        @(negedge clk);
        redir_valid = 1'b0;
        check("R8", {18'd0, mem_addr}, {18'd0, tgt});
        check("R8", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        mem[0]  = 8'hC1; mem[1]  = 8'h0E; mem[2]  = 8'h5A; mem[3]  = 8'h44;
        mem[4]  = 8'h34; mem[5]  = 8'hD2; mem[6]  = 8'h7E; mem[7]  = 8'hFF;
        mem[8]  = 8'hFF; mem[9]  = 8'h3E; mem[10] = 8'h00; mem[11] = 8'h06;
        mem[12] = 8'hA5; mem[13] = 8'h46; mem[14] = 8'h00; mem[15] = 8'h40;
        mem[16] = 8'hFF; mem[17] = 8'h04; mem[18] = 8'h4C; mem[19] = 8'h01;
        mem[20] = 8'h3F;
        mem[62] = 8'h44; mem[63] = 8'h78;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {31'd0, out_valid}, 32'd0);
        check("R1", {18'd0, mem_addr}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {31'd0, out_valid}, 32'd0);

        // R5: program walk with stalls on some records
        for (int i = 0; i < 10; i++)
            take(VREQ[i], VEC[i], (i % 3 == 1) ? 3 : 0);

        // R8: held record dropped by redirect; R6: straddle the wrap
        repeat (4) @(negedge clk);
        check("R7", {31'd0, out_valid}, 32'd1);
        check("R2", cur_rec(), {8'h00, 8'h00, 14'h0000, 2'd1});
        redirect(14'h3FFE);
        take("R6", {8'h44, 8'h00, 14'h0178, 2'd3}, 0);
        take("R6", {8'h0E, 8'h5A, 14'h0000, 2'd2}, 2);

        // R8: redirect while an address instruction is half collected
        redirect(14'h0003);
        @(negedge clk);
        @(negedge clk);
        redirect(14'h0010);
        take("R8", {8'hFF, 8'h00, 14'h0000, 2'd1}, 0);
        take("R5", {8'h04, 8'h00, 14'h0000, 2'd1}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule